// File: doc/BRIEF.md
# SDRAM command and timing controller

This block sits between a simple host port and one four-bank, 16-bit synchronous DRAM. It has one open row at a time and always closes that row again. A host request is taken with a valid/ready handshake. The controller opens the addressed row with a bank activate. After the activate-to-column delay it issues one read or write with auto-precharge, then waits until the bank is idle again. Read data returns on a separate strobe after the programmed CAS latency.

After reset the controller holds the bus idle for a programmable power-up delay. It then precharges all banks, issues two auto refreshes and programs the mode register. Only after that does it accept host traffic. From then on, an interval counter raises a refresh request. That request is served before any new host request, but only once the current access has finished.

Every spacing between commands is a cycle-count parameter. To run at a given clock, convert the nanosecond minimums of the memory into clock counts.

Top module: `sdram_ctrl`

## Requirements
- R1: While reset is asserted, the chip select output is high (no command), `sd_dq_oe_o` is low, `req_ready_o` is low and `rd_valid_o` is low.
- R2: After reset releases, the first command comes no sooner than `T_INIT` cycles later. The power-up sequence, in order, is: precharge with A10 high; at least `T_RP` cycles later an auto refresh; a second auto refresh; then a mode register set. The mode word puts burst length 1 in bits [2:0] = 000, sequential order in bit 3 = 0, `CL` in bits [6:4], and bit 9 = 0; all other bits and the bank are 0. `req_ready_o` stays low until the mode register set has been issued.
- R3: After a mode register set, no command follows for at least `T_MRD` cycles.
- R4: Host address `req_addr_i` is split as {bank[21:20], row[19:8], column[7:0]}. A bank activate carries the bank on `sd_ba_o` and the row on `sd_addr_o`. It is followed, no sooner than `T_RCD` cycles later, by exactly one read or write to the same bank. That column command has the column in `sd_addr_o[7:0]` and A10 high (auto-precharge).
- R5: Write data is on `sd_dq_o` with `sd_dq_oe_o` high in the same cycle as the write command. `sd_dqm_o[i]` is the inverse of `req_be_i[i]`, so disabled bytes are left unchanged in memory. `sd_dq_oe_o` is low in every cycle that carries a command other than a write.
- R6: For each accepted read, `rd_valid_o` pulses once with `rd_data_o` equal to `sd_dq_i` as sampled `CL` cycles after the memory samples the read command. Reads return in request order.
- R7: After a write with auto-precharge, the next command comes no sooner than max(`T_DPL`+`T_RP`, `T_RC`-`T_RCD`) cycles. After a read with auto-precharge, the gap is at least max(1+`T_RP`, `T_RC`-`T_RCD`) cycles.
- R8: After an auto refresh, no command follows for at least `T_RC` cycles.
- R9: Once power-up is complete, an auto refresh is issued every `REF_INTERVAL` cycles. A pending refresh wins over a waiting host request, but never cuts short an access already begun. Consecutive refreshes are therefore never more than `REF_INTERVAL` + `T_RCD` + max gap of R7 + 2 cycles apart, even under continuous host traffic.
- R10: Commands are encoded on {cs_n, ras_n, cas_n, we_n} with these values:

| Command | {cs_n, ras_n, cas_n, we_n} |
|---|---|
| mode set | 0000 |
| auto refresh | 0001 |
| precharge | 0010 |
| activate | 0011 |
| write | 0100 |
| read | 0101 |
| idle | 1111 |

  No other combination is ever driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, shared with the memory |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request present |
| req_ready_o | output | 1 | Controller takes the request on this edge |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 22 | {bank, row, column} |
| req_wdata_i | input | 16 | Write data |
| req_be_i | input | 2 | Byte enables for the write |
| rd_valid_o | output | 1 | Read data strobe |
| rd_data_o | output | 16 | Read data |
| sd_cs_n_o | output | 1 | Chip select, active low |
| sd_ras_n_o | output | 1 | Row strobe, active low |
| sd_cas_n_o | output | 1 | Column strobe, active low |
| sd_we_n_o | output | 1 | Write enable, active low |
| sd_ba_o | output | 2 | Bank select |
| sd_addr_o | output | 12 | Row, column or mode word |
| sd_dqm_o | output | 2 | Byte mask, per byte lane |
| sd_dq_o | output | 16 | Data toward the memory |
| sd_dq_oe_o | output | 1 | Drive enable for `sd_dq_o` |
| sd_dq_i | input | 16 | Data from the memory |

## Verification
The assertions assume that the host keeps the request fields stable from the cycle `req_valid_i` rises until the edge where `req_ready_o` is seen high. They also assume that `sd_dq_i` carries read data exactly at the latency set in the mode word. The bench meets both. Its driver holds each request until the handshake completes. Its memory model answers a read only through a pipeline of `CL` stages and writes only on the byte lanes that `sd_dqm_o` leaves open. The refresh interval in the bench is short, so refreshes land in the middle of dense back-to-back traffic. That stresses the priority rule without ever breaking the host protocol.

// File: rtl/sdram_ctrl_pkg.sv
package sdram_ctrl_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b1111
  } sdram_cmd_e;

  typedef enum logic [2:0] {
    ST_PWR,
    ST_IREF1,
    ST_IREF2,
    ST_IMRS,
    ST_IDLE,
    ST_COL
  } ctrl_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_ctrl_gap.sv
module sdram_ctrl_gap #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= W'(RST_VAL);
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  assign done_o = (cnt_q == '0);

  // R7: a new gap is only started once the previous one expired
  p_gap_reload_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> done_o);

endmodule

// File: rtl/sdram_ctrl_refresh.sv
module sdram_ctrl_refresh #(
  parameter int INTERVAL = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic pend_o
);

  localparam int CW = $clog2(INTERVAL + 1);

  logic [CW-1:0] cnt_q;
  logic          pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (cnt_q == CW'(INTERVAL - 1)) begin
      cnt_q  <= '0;
      pend_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + CW'(1);
      if (ack_i) pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;

  p_ack_pending_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |-> pend_q);

  p_pend_held_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !ack_i) |=> pend_q);

endmodule

// File: rtl/sdram_ctrl_rdpipe.sv
module sdram_ctrl_rdpipe #(
  parameter int CL = 3,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          issue_i,
  input  logic [DW-1:0] dq_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o
);

  // bit k set: read command has been on the pins for k+1 edges
  logic [CL:0]   sh_q;
  logic          valid_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      sh_q    <= {sh_q[CL-1:0], issue_i};
      valid_q <= sh_q[CL];
      if (sh_q[CL]) data_q <= dq_i;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;

  p_rd_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> $past(issue_i, CL + 2));

endmodule

// File: rtl/sdram_ctrl.sv
module sdram_ctrl
  import sdram_ctrl_pkg::*;
#(
  parameter int BANK_W       = 2,
  parameter int ROW_W        = 12,
  parameter int COL_W        = 8,
  parameter int DATA_W       = 16,
  parameter int CL           = 3,
  parameter int T_INIT       = 200,
  parameter int T_RCD        = 3,
  parameter int T_RP         = 3,
  parameter int T_RC         = 9,
  parameter int T_MRD        = 2,
  parameter int T_DPL        = 2,
  parameter int REF_INTERVAL = 2000
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            req_valid_i,
  output logic                            req_ready_o,
  input  logic                            req_write_i,
  input  logic [BANK_W+ROW_W+COL_W-1:0]   req_addr_i,
  input  logic [DATA_W-1:0]               req_wdata_i,
  input  logic [DATA_W/8-1:0]             req_be_i,
  output logic                            rd_valid_o,
  output logic [DATA_W-1:0]               rd_data_o,
  output logic                            sd_cs_n_o,
  output logic                            sd_ras_n_o,
  output logic                            sd_cas_n_o,
  output logic                            sd_we_n_o,
  output logic [BANK_W-1:0]               sd_ba_o,
  output logic [ROW_W-1:0]                sd_addr_o,
  output logic [DATA_W/8-1:0]             sd_dqm_o,
  output logic [DATA_W-1:0]               sd_dq_o,
  output logic                            sd_dq_oe_o,
  input  logic [DATA_W-1:0]               sd_dq_i
);

  localparam int ADDR_W = BANK_W + ROW_W + COL_W;
  localparam int BE_W   = DATA_W / 8;
  localparam int AP_BIT = 10;
  localparam int WR_GAP = imax(T_DPL + T_RP, T_RC - T_RCD);
  localparam int RD_GAP = imax(1 + T_RP, T_RC - T_RCD);
  localparam int MAX_GAP = imax(imax(imax(T_RC, T_RP), imax(T_RCD, T_MRD)),
                                imax(WR_GAP, RD_GAP));
  localparam int GW     = $clog2(imax(T_INIT, MAX_GAP) + 1);
  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'((CL & 7) << 4);

  ctrl_state_e          state_q, state_d;
  sdram_cmd_e           cmd_q, cmd_d;
  logic [BANK_W-1:0]    ba_q, ba_d;
  logic [ROW_W-1:0]     addr_q, addr_d;
  logic [BE_W-1:0]      dqm_q, dqm_d;
  logic [DATA_W-1:0]    dq_q, dq_d;
  logic                 oe_q, oe_d;

  logic [BANK_W-1:0]    bank_q;
  logic [COL_W-1:0]     col_q;
  logic                 wr_q;
  logic [DATA_W-1:0]    wdata_q;
  logic [BE_W-1:0]      be_q;

  logic                 gap_done, gap_load;
  logic [GW-1:0]        gap_val;
  logic                 ref_pend, ref_ack;
  logic                 accept, rd_issue;

  sdram_ctrl_gap #(.W(GW), .RST_VAL(T_INIT - 1)) u_gap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (gap_load),
    .val_i  (gap_val),
    .done_o (gap_done)
  );

  sdram_ctrl_refresh #(.INTERVAL(REF_INTERVAL)) u_refresh (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ack_i  (ref_ack),
    .pend_o (ref_pend)
  );

  sdram_ctrl_rdpipe #(.CL(CL), .DW(DATA_W)) u_rdpipe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (rd_issue),
    .dq_i    (sd_dq_i),
    .valid_o (rd_valid_o),
    .data_o  (rd_data_o)
  );

  assign req_ready_o = (state_q == ST_IDLE) && gap_done && !ref_pend;
  assign accept      = req_ready_o && req_valid_i;

  always_comb begin
    state_d  = state_q;
    cmd_d    = CMD_NOP;
    ba_d     = '0;
    addr_d   = '0;
    dqm_d    = '0;
    dq_d     = '0;
    oe_d     = 1'b0;
    gap_load = 1'b0;
    gap_val  = '0;
    ref_ack  = 1'b0;
    rd_issue = 1'b0;
    if (gap_done) begin
      unique case (state_q)
        ST_PWR: begin
          cmd_d          = CMD_PRE;
          addr_d[AP_BIT] = 1'b1;
          gap_load       = 1'b1;
          gap_val        = GW'(T_RP - 1);
          state_d        = ST_IREF1;
        end
        ST_IREF1, ST_IREF2: begin
          cmd_d    = CMD_REF;
          gap_load = 1'b1;
          gap_val  = GW'(T_RC - 1);
          state_d  = (state_q == ST_IREF1) ? ST_IREF2 : ST_IMRS;
        end
        ST_IMRS: begin
          cmd_d    = CMD_MRS;
          addr_d   = MODE_WORD;
          gap_load = 1'b1;
          gap_val  = GW'(T_MRD - 1);
          state_d  = ST_IDLE;
        end
        ST_IDLE: begin
          if (ref_pend) begin
            cmd_d    = CMD_REF;
            ref_ack  = 1'b1;
            gap_load = 1'b1;
            gap_val  = GW'(T_RC - 1);
          end else if (req_valid_i) begin
            cmd_d    = CMD_ACT;
            ba_d     = req_addr_i[ADDR_W-1 -: BANK_W];
            addr_d   = req_addr_i[COL_W +: ROW_W];
            gap_load = 1'b1;
            gap_val  = GW'(T_RCD - 1);
            state_d  = ST_COL;
          end
        end
        ST_COL: begin
          ba_d           = bank_q;
          addr_d         = ROW_W'(col_q);
          addr_d[AP_BIT] = 1'b1;
          gap_load       = 1'b1;
          state_d        = ST_IDLE;
          if (wr_q) begin
            cmd_d   = CMD_WR;
            dq_d    = wdata_q;
            oe_d    = 1'b1;
            dqm_d   = ~be_q;
            gap_val = GW'(WR_GAP - 1);
          end else begin
            cmd_d    = CMD_RD;
            rd_issue = 1'b1;
            gap_val  = GW'(RD_GAP - 1);
          end
        end
        default: state_d = ST_PWR;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PWR;
      cmd_q   <= CMD_NOP;
      ba_q    <= '0;
      addr_q  <= '0;
      dqm_q   <= '0;
      dq_q    <= '0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      ba_q    <= ba_d;
      addr_q  <= addr_d;
      dqm_q   <= dqm_d;
      dq_q    <= dq_d;
      oe_q    <= oe_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q  <= '0;
      col_q   <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept) begin
      bank_q  <= req_addr_i[ADDR_W-1 -: BANK_W];
      col_q   <= req_addr_i[COL_W-1:0];
      wr_q    <= req_write_i;
      wdata_q <= req_wdata_i;
      be_q    <= req_be_i;
    end
  end

  assign sd_cs_n_o  = cmd_q[3];
  assign sd_ras_n_o = cmd_q[2];
  assign sd_cas_n_o = cmd_q[1];
  assign sd_we_n_o  = cmd_q[0];
  assign sd_ba_o    = ba_q;
  assign sd_addr_o  = addr_q;
  assign sd_dqm_o   = dqm_q;
  assign sd_dq_o    = dq_q;
  assign sd_dq_oe_o = oe_q;

  // pin-level spacing observer for the assertions below
  localparam int SW = $clog2(imax(T_INIT, MAX_GAP) + 2) + 1;
  localparam logic [SW-1:0] MRD_C = SW'(T_MRD);
  localparam logic [SW-1:0] RC_C  = SW'(T_RC);
  localparam logic [SW-1:0] RCD_C = SW'(T_RCD);
  localparam logic [SW-1:0] WRG_C = SW'(WR_GAP);
  localparam logic [SW-1:0] RDG_C = SW'(RD_GAP);

  logic [SW-1:0] since_q;
  sdram_cmd_e    last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q <= '0;
      last_q  <= CMD_NOP;
    end else if (!cmd_q[3]) begin
      since_q <= SW'(1);
      last_q  <= cmd_q;
    end else if (since_q != '1) begin
      since_q <= since_q + SW'(1);
    end
  end

  p_mrs_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sd_cs_n_o && last_q == CMD_MRS) |-> (since_q >= MRD_C));

  p_act_col_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sd_cs_n_o && last_q == CMD_ACT) |->
      ((cmd_q == CMD_RD || cmd_q == CMD_WR) && since_q >= RCD_C && sd_addr_o[AP_BIT]));

  p_oe_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_dq_oe_o |-> (cmd_q == CMD_WR));

  p_wr_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sd_cs_n_o && last_q == CMD_WR) |-> (since_q >= WRG_C));

  p_rd_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sd_cs_n_o && last_q == CMD_RD) |-> (since_q >= RDG_C));

  p_ref_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sd_cs_n_o && last_q == CMD_REF) |-> (since_q >= RC_C));

endmodule

// File: tb/sdram_ctrl_bench.sv
`timescale 1ns/1ps
module sdram_ctrl_bench;

  localparam int CL     = 3;
  localparam int T_INIT = 20;
  localparam int T_RCD  = 3;
  localparam int T_RP   = 3;
  localparam int T_RC   = 9;
  localparam int T_MRD  = 2;
  localparam int T_DPL  = 2;
  localparam int REF_IV = 150;
  localparam int WRG    = ((T_DPL + T_RP) > (T_RC - T_RCD)) ? (T_DPL + T_RP) : (T_RC - T_RCD);
  localparam int RDG    = ((1 + T_RP) > (T_RC - T_RCD)) ? (1 + T_RP) : (T_RC - T_RCD);
  localparam int MAXG   = (WRG > RDG) ? WRG : RDG;
  localparam int REF_BOUND = REF_IV + T_RCD + MAXG + 2;
  localparam logic [11:0] MODE_EXP = 12'(CL << 4);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [21:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic req_ready_o, rd_valid_o;
  logic [15:0] rd_data_o;
  logic sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o, sd_dq_oe_o;
  logic [1:0]  sd_ba_o, sd_dqm_o;
  logic [11:0] sd_addr_o;
  logic [15:0] sd_dq_o;
  logic [15:0] dq_in = '0;

  always #2.5 clk = ~clk;

  sdram_ctrl #(
    .CL(CL), .T_INIT(T_INIT), .T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC),
    .T_MRD(T_MRD), .T_DPL(T_DPL), .REF_INTERVAL(REF_IV)
  ) u_sdram_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(req_ready_o), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_be_i(req_be),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .sd_cs_n_o(sd_cs_n_o), .sd_ras_n_o(sd_ras_n_o), .sd_cas_n_o(sd_cas_n_o),
    .sd_we_n_o(sd_we_n_o), .sd_ba_o(sd_ba_o), .sd_addr_o(sd_addr_o),
    .sd_dqm_o(sd_dqm_o), .sd_dq_o(sd_dq_o), .sd_dq_oe_o(sd_dq_oe_o),
    .sd_dq_i(dq_in)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [15:0] ref_mem [logic [21:0]];
  logic [15:0] dev_mem [logic [21:0]];
  logic [15:0] exp_q [$];

  // driver: pushes expected read data into the scoreboard at acceptance
  task automatic host_req(input bit wr, input logic [21:0] a, input logic [15:0] d, input logic [1:0] be);
    logic [15:0] v;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready_o) @(negedge clk);
    v = ref_mem.exists(a) ? ref_mem[a] : 16'h0;
    if (wr) begin
      if (be[0]) v[7:0]  = d[7:0];
      if (be[1]) v[15:8] = d[15:8];
      ref_mem[a] = v;
    end else begin
      exp_q.push_back(v);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // memory model and command monitor
  int cyc = 0, rel_cyc = 0, last_cyc = 0, init_idx = 0;
  int prev_ref = 0, n_ref = 0;
  bit have_last = 1'b0, have_ref = 1'b0;
  logic [3:0]  last_cmd = 4'hf;
  logic [1:0]  act_ba = '0;
  logic [11:0] open_row [4];
  logic [15:0] pipe [CL+1];

  always @(negedge clk) begin
    logic [3:0] c;
    logic [21:0] key;
    logic [15:0] v;
    int gap;
    cyc++;
    if (!rst_ni) rel_cyc = cyc;
    for (int i = CL; i > 0; i--) pipe[i] = pipe[i-1];
    pipe[0] = 16'h0;
    c = {sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o};
    if (rst_ni && init_idx < 4) check(!req_ready_o, "R2 ready before init", 32'(req_ready_o), 0);
    if (rst_ni && !sd_cs_n_o) begin
      check(c inside {4'b0000, 4'b0001, 4'b0010, 4'b0011, 4'b0100, 4'b0101}, "R10 encoding", 32'(c), 0);
      gap = cyc - last_cyc;
      if (!have_last) check(gap >= T_INIT, "R2 power-up delay", 32'(cyc - rel_cyc), 32'(T_INIT));
      else begin
        case (last_cmd)
          4'b0000: check(gap >= T_MRD, "R3 mrs gap", 32'(gap), 32'(T_MRD));
          4'b0001: check(gap >= T_RC,  "R8 refresh gap", 32'(gap), 32'(T_RC));
          4'b0010: check(gap >= T_RP,  "R2 precharge gap", 32'(gap), 32'(T_RP));
          4'b0011: begin
            check(c == 4'b0100 || c == 4'b0101, "R4 column after act", 32'(c), 32'h4);
            check(gap >= T_RCD, "R4 rcd gap", 32'(gap), 32'(T_RCD));
            check(sd_ba_o == act_ba, "R4 same bank", 32'(sd_ba_o), 32'(act_ba));
          end
          4'b0100: check(gap >= WRG, "R7 write gap", 32'(gap), 32'(WRG));
          4'b0101: check(gap >= RDG, "R7 read gap", 32'(gap), 32'(RDG));
          default: ;
        endcase
      end
      if (init_idx < 4) begin
        case (init_idx)
          0: check(c == 4'b0010 && sd_addr_o[10], "R2 precharge all", 32'({c, sd_addr_o}), 32'h2400);
          1, 2: check(c == 4'b0001, "R2 init refresh", 32'(c), 32'h1);
          default: check(c == 4'b0000 && sd_addr_o == MODE_EXP && sd_ba_o == 2'b00,
                         "R2 mode word", 32'({c, sd_ba_o, sd_addr_o}), 32'(MODE_EXP));
        endcase
        init_idx++;
      end else if (c == 4'b0001) begin
        if (have_ref) check(cyc - prev_ref <= REF_BOUND, "R9 refresh period", 32'(cyc - prev_ref), 32'(REF_BOUND));
        have_ref = 1'b1; prev_ref = cyc; n_ref++;
      end
      check(sd_dq_oe_o == (c == 4'b0100), "R5 drive enable", 32'(sd_dq_oe_o), 32'(c == 4'b0100));
      if (c == 4'b0011) begin
        act_ba = sd_ba_o;
        open_row[sd_ba_o] = sd_addr_o;
      end
      if (c == 4'b0100 || c == 4'b0101) begin
        check(sd_addr_o[10], "R4 auto-precharge", 32'(sd_addr_o[10]), 1);
        key = {sd_ba_o, open_row[sd_ba_o], sd_addr_o[7:0]};
        v = dev_mem.exists(key) ? dev_mem[key] : 16'h0;
        if (c == 4'b0100) begin
          if (!sd_dqm_o[0]) v[7:0]  = sd_dq_o[7:0];
          if (!sd_dqm_o[1]) v[15:8] = sd_dq_o[15:8];
          dev_mem[key] = v;
        end else begin
          pipe[0] = v;
        end
      end
      last_cmd = c; last_cyc = cyc; have_last = 1'b1;
    end
    dq_in = pipe[CL];
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni && rd_valid_o) begin
      if (exp_q.size() == 0) check(1'b0, "R6 unexpected read data", 32'(rd_data_o), 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(rd_data_o == e, "R6 read data", 32'(rd_data_o), 32'(e));
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd == 100000) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  function automatic logic [21:0] mk_addr(input int i);
    return {2'(i), 12'((i * 37 + 5) % 4096), 8'((i * 13 + 1) % 256)};
  endfunction

  initial begin
    for (int b = 0; b < 4; b++) open_row[b] = '0;
    for (int i = 0; i <= CL; i++) pipe[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(sd_cs_n_o == 1'b1, "R1 no command in reset", 32'(sd_cs_n_o), 1);
    check(sd_dq_oe_o == 1'b0, "R1 drive off in reset", 32'(sd_dq_oe_o), 0);
    check(req_ready_o == 1'b0, "R1 ready low in reset", 32'(req_ready_o), 0);
    check(rd_valid_o == 1'b0, "R1 no read strobe in reset", 32'(rd_valid_o), 0);
    @(negedge clk); #1 rst_ni = 1'b1;
    while (!req_ready_o) @(negedge clk);
    check(init_idx == 4, "R2 sequence complete", 32'(init_idx), 4);

    // one word per bank, then read back
    for (int i = 0; i < 4; i++) host_req(1'b1, mk_addr(i), 16'hA500 + 16'(i * 17), 2'b11);
    for (int i = 0; i < 4; i++) host_req(1'b0, mk_addr(i), '0, 2'b11);
    // R5: byte masks leave the other lane unchanged
    host_req(1'b1, mk_addr(0), 16'h1234, 2'b01);
    host_req(1'b0, mk_addr(0), '0, 2'b11);
    host_req(1'b1, mk_addr(1), 16'h5678, 2'b10);
    host_req(1'b0, mk_addr(1), '0, 2'b11);
    host_req(1'b1, mk_addr(2), 16'hFFFF, 2'b00);
    host_req(1'b0, mk_addr(2), '0, 2'b11);
    // R9: dense traffic across refresh intervals
    for (int i = 4; i < 52; i++) host_req(1'b1, mk_addr(i), 16'(i * 2749 + 3), 2'b11);
    for (int i = 51; i >= 4; i--) host_req(1'b0, mk_addr(i), '0, 2'b11);
    // mixed order, read of a location never written
    for (int i = 0; i < 8; i++) begin
      host_req(1'b1, mk_addr(100 + i), 16'(16'hC0DE ^ 16'(i)), 2'b11);
      host_req(1'b0, mk_addr(100 + i), '0, 2'b11);
    end
    host_req(1'b0, 22'h3FFFFF, '0, 2'b11);

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R6 all reads returned", 32'(exp_q.size()), 0);
    check(n_ref >= 2, "R9 periodic refresh seen", 32'(n_ref), 2);
    finish_run();
  end

endmodule